// File: doc/BRIEF.md
# Halt Mode Wake Controller

This controller sits beside the CPU of a small microcontroller that runs from its on-chip oscillator. When software asks to halt, it stops the CPU clock and turns off the main crystal oscillator. The internal oscillator and the peripheral clocks keep running, so timers and other interrupt sources can still wake the CPU.

Waking and accepting an interrupt are two separate decisions. Any non-maskable interrupt (NMI), or any maskable request whose mask bit is clear, ends the halt, whatever its priority. An interrupt is acknowledged only when the global enable allows it and the request outranks the level that is currently in service. The NMI is always acknowledged. When no acknowledge is given, the block pulses a "continue with the next instruction" indication instead.

After reset the block waits in internal-oscillator run mode until the main oscillator reports that it is valid. It then moves to normal run mode.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After reset the mode output is 2'b01 (internal-oscillator run). At the first clock edge at which mosc_ok is 1 the mode becomes 2'b00 (normal run). While mosc_ok stays 0 the mode stays 2'b01.
- R2: A halt_req sampled in mode 2'b01 moves the mode to 2'b10 (halted) and drives cpu_clk_en low from that edge. A later wake returns to 2'b01 and never to 2'b00, even when mosc_ok is 1. per_clk_en is 1 in every cycle.
- R3: mosc_en is 0 in every cycle the block is halted and 1 in every other cycle.
- R4: halt_req has no effect in mode 2'b00 or while already halted.
- R5: While halted, the block wakes at the first edge that sees nmi=1 or any request with irq_pend[i]=1 and irq_mask[i]=0 (mask bit 1 means masked). At that edge the mode becomes 2'b01 and cpu_clk_en becomes 1. Masked requests never wake it.
- R6: If an unmasked request is already pending when halt_req is taken, the block stays halted for exactly one cycle.
- R7: At the wake edge an NMI gives ack=1, ack_nmi=1 and ack_idx=0. A maskable wake gives ack=1 only when gie=1 and either insvc_valid=0 or the winner's priority is strictly greater than insvc_prio. ack is a one-cycle pulse.
- R8: Request i has its priority in irq_prio[i*PRIO_W +: PRIO_W], and a larger value ranks higher. The winner is the lowest index among the unmasked pending requests that share the highest priority.
- R9: A wake that is not acknowledged pulses resume_next for one cycle. resume_next and ack are never 1 together.
- R10: A reset while halted restores the R1 behaviour: mode 2'b01, then 2'b00 once mosc_ok is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Halt request strobe from the CPU |
| irq_pend | input | N_IRQ | Maskable request lines |
| irq_mask | input | N_IRQ | Mask bits, 1 = masked |
| irq_prio | input | N_IRQ*PRIO_W | Priority field of each request |
| nmi | input | 1 | Non-maskable interrupt request |
| insvc_valid | input | 1 | An interrupt is currently being serviced |
| insvc_prio | input | PRIO_W | Priority of the interrupt in service |
| gie | input | 1 | Global interrupt enable |
| mosc_ok | input | 1 | Main oscillator valid |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| mosc_en | output | 1 | Main oscillator enable |
| ack | output | 1 | Interrupt acknowledge pulse |
| ack_nmi | output | 1 | Acknowledge is for the NMI |
| ack_idx | output | $clog2(N_IRQ) | Index of the acknowledged request |
| resume_next | output | 1 | Resume at next instruction, no branch |
| mode | output | 2 | 00 normal, 01 internal run, 10 halted |

## Verification
The wake decision and the acknowledge decision are taken at the same clock edge, so one edge must produce both the mode change and the choice between ack and resume_next. The bench provokes this edge with an NMI, with several requests that tie or differ in priority, with requests that are outranked by or equal to the in-service level, and with gie low. A second collision happens when a request is already pending as halt_req arrives. In that case entry and exit fall on back-to-back edges. A behavioural model with its own priority scan judges every output on every clock.

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl #(
  parameter int N_IRQ  = 8,
  parameter int PRIO_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      halt_req,
  input  logic [N_IRQ-1:0]          irq_pend,
  input  logic [N_IRQ-1:0]          irq_mask,
  input  logic [N_IRQ*PRIO_W-1:0]   irq_prio,
  input  logic                      nmi,
  input  logic                      insvc_valid,
  input  logic [PRIO_W-1:0]         insvc_prio,
  input  logic                      gie,
  input  logic                      mosc_ok,
  output logic                      cpu_clk_en,
  output logic                      per_clk_en,
  output logic                      mosc_en,
  output logic                      ack,
  output logic                      ack_nmi,
  output logic [$clog2(N_IRQ)-1:0]  ack_idx,
  output logic                      resume_next,
  output logic [1:0]                mode
);
  localparam int IDX_W = $clog2(N_IRQ);
  localparam logic [1:0] M_NORM = 2'b00, M_IRUN = 2'b01, M_HALT = 2'b10;

  logic [1:0]       mode_q;
  logic             boot_q, cpu_q, mosc_q, ack_q, nmi_q, res_q;
  logic [IDX_W-1:0] idx_q;
  logic [N_IRQ-1:0] live;
  logic             any_live, wake, take;
  logic [PRIO_W-1:0] best_p;
  logic [IDX_W-1:0]  best_i;

  assign live     = irq_pend & ~irq_mask;
  assign any_live = |live;
  assign wake     = nmi | any_live;

  always_comb begin
    best_p = '0;
    best_i = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (live[i] && irq_prio[i*PRIO_W +: PRIO_W] >= best_p) begin
        best_p = irq_prio[i*PRIO_W +: PRIO_W];
        best_i = IDX_W'(i);
      end
    end
  end

  assign take = gie && (!insvc_valid || best_p > insvc_prio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_IRUN;
      boot_q <= 1'b1;
      cpu_q  <= 1'b1;
      mosc_q <= 1'b1;
      ack_q  <= 1'b0;
      nmi_q  <= 1'b0;
      res_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      ack_q <= 1'b0;
      nmi_q <= 1'b0;
      res_q <= 1'b0;
      idx_q <= '0;
      case (mode_q)
        M_IRUN: begin
          if (halt_req) begin
            mode_q <= M_HALT;
            cpu_q  <= 1'b0;
            mosc_q <= 1'b0;
            boot_q <= 1'b0;
          end else if (boot_q && mosc_ok) begin
            mode_q <= M_NORM;
            boot_q <= 1'b0;
          end
        end
        M_HALT: begin
          if (wake) begin
            mode_q <= M_IRUN;
            cpu_q  <= 1'b1;
            mosc_q <= 1'b1;
            if (nmi) begin
              ack_q <= 1'b1;
              nmi_q <= 1'b1;
            end else if (take) begin
              ack_q <= 1'b1;
              idx_q <= best_i;
            end else begin
              res_q <= 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign mode        = mode_q;
  assign cpu_clk_en  = cpu_q;
  assign mosc_en     = mosc_q;
  assign per_clk_en  = 1'b1;
  assign ack         = ack_q;
  assign ack_nmi     = nmi_q;
  assign ack_idx     = idx_q;
  assign resume_next = res_q;

  assert_gate_off_in_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HALT) |-> !cpu_q);
  assert_mosc_off_in_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HALT) == !mosc_q);
  assert_norm_ignores_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_NORM) |=> (mode_q == M_NORM));
  assert_stay_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HALT && !wake) |=> (mode_q == M_HALT));
  assert_wake_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_q) |-> $past(wake));
  assert_ack_needs_gie_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && !nmi_q) |-> $past(gie));
  assert_ack_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  assert_ack_or_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_q, res_q}));
endmodule

// File: tb/halt_wake_ctrl_tb.sv
module halt_wake_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int N  = 8;
  localparam int PW = 2;

  logic clk = 0, rst_n = 0;
  logic halt_req = 0, nmi = 0, insvc_valid = 0, gie = 0, mosc_ok = 0;
  logic [N-1:0] irq_pend = '0, irq_mask = '1;
  logic [N*PW-1:0] irq_prio = '0;
  logic [PW-1:0] insvc_prio = '0;
  logic cpu_clk_en, per_clk_en, mosc_en, ack, ack_nmi, resume_next;
  logic [2:0] ack_idx;
  logic [1:0] mode;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_mode, m_idx, win;
  bit m_boot, m_cpu, m_mosc, m_ack, m_nmi, m_res;

  halt_wake_ctrl #(.N_IRQ(N), .PRIO_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .irq_pend(irq_pend),
    .irq_mask(irq_mask), .irq_prio(irq_prio), .nmi(nmi),
    .insvc_valid(insvc_valid), .insvc_prio(insvc_prio), .gie(gie),
    .mosc_ok(mosc_ok), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .mosc_en(mosc_en), .ack(ack), .ack_nmi(ack_nmi), .ack_idx(ack_idx),
    .resume_next(resume_next), .mode(mode));

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 1; m_boot = 1; m_cpu = 1; m_mosc = 1;
      m_ack = 0; m_nmi = 0; m_res = 0; m_idx = 0;
    end else begin
      m_ack = 0; m_nmi = 0; m_res = 0; m_idx = 0;
      if (m_mode == 1) begin
        if (halt_req) begin
          m_mode = 2; m_cpu = 0; m_mosc = 0; m_boot = 0;
        end else if (m_boot && mosc_ok) begin
          m_mode = 0; m_boot = 0;
        end
      end else if (m_mode == 2) begin
        win = -1;
        for (int p = (1 << PW) - 1; p >= 0; p--)
          for (int i = 0; i < N; i++)
            if (win < 0 && irq_pend[i] && !irq_mask[i] && int'(irq_prio[i*PW +: PW]) == p)
              win = i;
        if (nmi || win >= 0) begin
          m_mode = 1; m_cpu = 1; m_mosc = 1;
          if (nmi) begin
            m_ack = 1; m_nmi = 1;
          end else if (gie && (!insvc_valid || int'(irq_prio[win*PW +: PW]) > int'(insvc_prio))) begin
            m_ack = 1; m_idx = win;
          end else m_res = 1;
        end
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1", "mode", int'(mode), m_mode);
      chk("R2", "cpu_clk_en", int'(cpu_clk_en), int'(m_cpu));
      chk("R2", "per_clk_en", int'(per_clk_en), 1);
      chk("R3", "mosc_en", int'(mosc_en), int'(m_mosc));
      chk("R7", "ack", int'(ack), int'(m_ack));
      chk("R7", "ack_nmi", int'(ack_nmi), int'(m_nmi));
      if (ack) chk("R8", "ack_idx", int'(ack_idx), m_idx);
      chk("R9", "resume_next", int'(resume_next), int'(m_res));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic at_neg(string tag, string what, int act_sel, int exp);
    @(negedge clk);
    chk(tag, what, act_sel == 0 ? int'(mode) : act_sel == 1 ? int'(ack) :
        act_sel == 2 ? int'(ack_idx) : int'(resume_next), exp);
  endtask

  task automatic do_halt();
    halt_req = 1; cyc(1); halt_req = 0;
  endtask

  task automatic set_prio(int i, int p);
    irq_prio[i*PW +: PW] = PW'(p);
  endtask

  initial begin
    #(CLK_P * 50000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cyc(2); rst_n = 1; cyc(3);
    at_neg("R1", "waits for main osc", 0, 1);
    cyc(1); mosc_ok = 1; cyc(1);
    at_neg("R1", "normal after valid", 0, 0);
    cyc(1); do_halt(); cyc(2);
    at_neg("R4", "halt ignored in normal", 0, 0);

    // R10 path from a fresh boot, then R2 halt without valid main osc
    rst_n = 0; mosc_ok = 0; cyc(1); rst_n = 1; cyc(2);
    do_halt(); cyc(3);
    at_neg("R2", "halted", 0, 2);
    do_halt(); cyc(1);
    at_neg("R4", "halt_req while halted", 0, 2);
    irq_pend[3] = 1; set_prio(3, 3); gie = 1; cyc(3);
    at_neg("R5", "masked request no wake", 0, 2);
    // lower than in-service: wake, no ack, resume (R9)
    insvc_valid = 1; insvc_prio = 2; set_prio(3, 1); irq_mask[3] = 0; cyc(1);
    at_neg("R9", "resume on outranked wake", 3, 1);
    irq_pend = '0; mosc_ok = 1; cyc(3);
    at_neg("R2", "wake returns to internal run", 0, 1);

    // NMI wake (R7)
    do_halt(); cyc(2); nmi = 1; cyc(1); nmi = 0;
    at_neg("R7", "nmi ack", 1, 1);
    cyc(1);

    // arbitration tie (R8)
    do_halt(); cyc(2);
    irq_mask = '0; insvc_prio = 1;
    set_prio(5, 3); set_prio(2, 3); set_prio(0, 2);
    irq_pend = 8'b0010_0101; cyc(1);
    at_neg("R8", "lowest index at top priority", 2, 2);
    irq_pend = '0; cyc(1);

    // equal priority is not acknowledged (R7)
    do_halt(); cyc(1);
    set_prio(6, 2); insvc_prio = 2; irq_pend[6] = 1; cyc(1);
    at_neg("R7", "equal priority no ack", 1, 0);
    irq_pend = '0; cyc(1);

    // gie low (R9)
    gie = 0; insvc_valid = 0;
    do_halt(); cyc(1); irq_pend[1] = 1; cyc(1);
    at_neg("R9", "gie low resumes", 3, 1);
    irq_pend = '0; gie = 1; cyc(1);

    // pending at entry (R6)
    irq_pend[4] = 1; set_prio(4, 1); halt_req = 1; cyc(1); halt_req = 0;
    @(negedge clk); chk("R6", "entered halt", int'(mode), 2);
    @(negedge clk); chk("R6", "left after one cycle", int'(mode), 1);
    chk("R6", "acked idx 4", int'(ack_idx), 4);
    cyc(1); irq_pend = '0; cyc(1);

    // reset during halt (R10)
    do_halt(); cyc(2); rst_n = 0; cyc(1); rst_n = 1; mosc_ok = 1; cyc(1);
    at_neg("R10", "normal after reset in halt", 0, 0);
    cyc(3);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule